// File: doc/BRIEF.md
# Secondary Controller Online Gate

This block tracks whether each secondary (virtual-function) controller is online or offline, and applies the effects of that state. The command engine sends online and offline requests that name a secondary by identifier. Each request gets a registered status one cycle after it is accepted. A secondary that actually changes state gets a one-cycle function-reset pulse. Every offline request also sends a release request back to the command engine, so that the engine can return the secondary's interrupt and queue resources to the pool.

The block sits in front of each secondary's register file. While a secondary is offline, every access except one to the controller-status register is blocked. Reads of the status register from an offline secondary show the fatal bit forced on. Enable attempts are granted only while the secondary is online.

Two events force secondaries offline. A configuration write that clears the virtual-function-enable bit does so for the enabled secondaries, and a primary reset does so for all of them. These forced transitions are queued and handled one secondary per cycle.

Top module: `sec_online_gate`

## Requirements
- R1: After reset, every secondary is offline, `cmd_ready` is 1, and `rsp_valid`, `rel_valid` and `func_rst` are all 0.
- R2: The identifier of secondary index i is i+ID_BASE. An accepted request with any other identifier returns status 0x11F one cycle later and changes no state. It produces no reset pulse and no release.
- R3: An accepted online request returns status 0x120 and leaves the state unchanged when any of the following holds: the interrupt count is zero, the queue count is below two, or the secondary has no backing function. A secondary has a backing function only when the latched enable bit is 1 and its index is below `vf_count`.
- R4: A successful online request for an offline secondary returns status 0. One cycle after acceptance, its state is set and its `func_rst` bit pulses for one cycle.
- R5: An online request that passes the checks of R3 for a secondary that is already online returns status 0 and gives no reset pulse.
- R6: An offline request for a known secondary returns status 0 and always issues one release request (`rel_valid` with `rel_idx` = index) in the following cycle. The state is cleared and `func_rst` pulses only if the secondary was online.
- R7: While secondary i is offline, an access at any address other than 0x1C is not forwarded (`fwd_rd`, `fwd_wr` = 0), and `up_rdata` reads zero.
- R8: Accesses at the status address 0x1C are always forwarded. When the secondary is offline, `up_rdata` is `dn_rdata` with bit 1 (fatal) forced to 1. When it is online, all accesses pass through unchanged.
- R9: `en_grant[i]` equals `en_req[i]` while secondary i is online, and is 0 while it is offline.
- R10: A configuration write with `cfg_vfe` = 0 queues every secondary with index below `vf_count` for forced offline. An active `prim_rst` queues all secondaries. `cfg_wr` latches `cfg_vfe` as the enable bit.
- R11: Queued secondaries are handled one per cycle, lowest index first. Each one issues a release and, if it was online, goes offline with a reset pulse. `cmd_ready` is 0 while the queue is non-empty.
- R12: At most one `func_rst` bit is high in any cycle, and a pulse only ever accompanies a change of that secondary's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Online/offline request present |
| cmd_ready | output | 1 | Request accepted this cycle (low while force queue busy) |
| cmd_online | input | 1 | 1 = online request, 0 = offline request |
| cmd_id | input | ID_W | Secondary identifier |
| cmd_irq_cnt | input | CNT_W | Interrupts currently held by the secondary |
| cmd_q_cnt | input | CNT_W | Queues currently held by the secondary |
| rsp_valid | output | 1 | Status of the accepted request |
| rsp_status | output | 16 | 0, 0x11F or 0x120 |
| rel_valid | output | 1 | Release request for one secondary's resources |
| rel_idx | output | IDX_W | Index whose resources go back to the pool |
| cfg_wr | input | 1 | Configuration write to the enable control |
| cfg_vfe | input | 1 | Written value of the virtual-function-enable bit |
| vf_count | input | VFC_W | Number of backed secondaries |
| prim_rst | input | 1 | Primary controller reset |
| func_rst | output | NUM_SEC | Function-reset pulse per secondary |
| online | output | NUM_SEC | Online state per secondary |
| en_req | input | NUM_SEC | Enable attempt per secondary |
| en_grant | output | NUM_SEC | Enable attempt allowed |
| acc_rd | input | NUM_SEC | Register read strobe per secondary |
| acc_wr | input | NUM_SEC | Register write strobe per secondary |
| acc_addr | input | NUM_SEC x ADDR_W | Register offset per secondary |
| dn_rdata | input | NUM_SEC x DATA_W | Read data from each register file |
| fwd_rd | output | NUM_SEC | Read strobe passed to the register file |
| fwd_wr | output | NUM_SEC | Write strobe passed to the register file |
| up_rdata | output | NUM_SEC x DATA_W | Read data returned to the host |

## Verification
The assertions check the following on every cycle:
- no more than one reset pulse is high, and each pulse matches a state change of that secondary;
- a secondary only comes online together with a success response;
- responses follow accepted requests, and an unknown-identifier response leaves the state untouched;
- accesses to an offline secondary that do not target the status register are never forwarded.

Only the bench's scenarios can show the rest:
- the three online refusal conditions (R3);
- the difference between a release-only offline and an offline that resets (R6);
- the ascending, one-per-cycle walk of the force queue after an enable clear or a primary reset (R10, R11).

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;

    localparam int STS_W = 16;

    localparam logic [STS_W-1:0] ST_OK        = 16'h0000;
    localparam logic [STS_W-1:0] ST_BAD_ID    = 16'h011F;
    localparam logic [STS_W-1:0] ST_BAD_STATE = 16'h0120;

    // controller-status register offset and its fatal bit
    localparam int STS_OFFSET    = 32'h1C;
    localparam int STS_FATAL_BIT = 1;

    // minimum queue count (admin + one I/O) for an online secondary
    localparam int MIN_QUEUES = 2;

    typedef enum logic [2:0] {
        OUT_NONE,
        OUT_BAD_ID,
        OUT_REFUSED,
        OUT_RAISE,
        OUT_KEEP,
        OUT_DROP
    } cmd_outcome_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sec_cmd_decode.sv
module sec_cmd_decode
    import sec_gate_pkg::*;
#(
    parameter int NUM_SEC = 4,
    parameter int ID_W    = 16,
    parameter int CNT_W   = 16,
    parameter int ID_BASE = 1,
    localparam int IDX_W  = idx_width(NUM_SEC),
    localparam int VFC_W  = $clog2(NUM_SEC + 1)
) (
    input  logic [ID_W-1:0]  cmd_id,
    input  logic [CNT_W-1:0] irq_cnt,
    input  logic [CNT_W-1:0] q_cnt,
    input  logic             vfe,
    input  logic [VFC_W-1:0] vf_count,
    output logic             id_ok,
    output logic [IDX_W-1:0] idx,
    output logic             can_online
);

    logic [ID_W:0] off_w;
    logic          backed;

    always_comb begin
        off_w      = {1'b0, cmd_id} - (ID_W + 1)'(ID_BASE);
        id_ok      = !off_w[ID_W] && (off_w < (ID_W + 1)'(NUM_SEC));
        idx        = off_w[IDX_W-1:0];
        backed     = vfe && (int'(idx) < int'(vf_count));
        can_online = (irq_cnt != '0) && (q_cnt >= CNT_W'(MIN_QUEUES)) && backed;
    end

endmodule

// File: rtl/sec_state_ctrl.sv
module sec_state_ctrl
    import sec_gate_pkg::*;
#(
    parameter int NUM_SEC = 4,
    localparam int IDX_W  = idx_width(NUM_SEC),
    localparam int VFC_W  = $clog2(NUM_SEC + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_online,
    input  logic               id_ok,
    input  logic [IDX_W-1:0]   idx,
    input  logic               can_online,
    input  logic               cfg_wr,
    input  logic               cfg_vfe,
    input  logic [VFC_W-1:0]   vf_count,
    input  logic               prim_rst,
    output logic               vfe,
    output logic               rsp_valid,
    output logic [STS_W-1:0]   rsp_status,
    output logic               rel_valid,
    output logic [IDX_W-1:0]   rel_idx,
    output logic [NUM_SEC-1:0] func_rst,
    output logic [NUM_SEC-1:0] online
);

    logic [NUM_SEC-1:0] pend_q, online_q, func_rst_q;
    logic [NUM_SEC-1:0] set_mask, below_mask, pick_hot;
    logic               vfe_q, rsp_valid_q, rel_valid_q;
    logic [STS_W-1:0]   rsp_status_q;
    logic [IDX_W-1:0]   rel_idx_q, pick_idx;
    logic               pick_found, accept;
    cmd_outcome_e       outcome;

    // lowest pending index wins
    always_comb begin
        pick_found = 1'b0;
        pick_idx   = '0;
        for (int i = NUM_SEC - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                pick_found = 1'b1;
                pick_idx   = IDX_W'(i);
            end
        end
        pick_hot = NUM_SEC'(pick_found) << pick_idx;
    end

    generate
        for (genvar g = 0; g < NUM_SEC; g++) begin : g_below
            assign below_mask[g] = (g < int'(vf_count));
        end
    endgenerate

    always_comb begin
        set_mask = '0;
        if (prim_rst)
            set_mask = '1;
        if (cfg_wr && !cfg_vfe)
            set_mask = set_mask | below_mask;
    end

    assign cmd_ready = (pend_q == '0);
    assign accept    = cmd_valid && cmd_ready;

    always_comb begin
        outcome = OUT_NONE;
        if (accept) begin
            if (!id_ok)
                outcome = OUT_BAD_ID;
            else if (cmd_online)
                outcome = !can_online   ? OUT_REFUSED :
                          online_q[idx] ? OUT_KEEP    : OUT_RAISE;
            else
                outcome = OUT_DROP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q       <= '0;
            online_q     <= '0;
            func_rst_q   <= '0;
            vfe_q        <= 1'b0;
            rsp_valid_q  <= 1'b0;
            rsp_status_q <= ST_OK;
            rel_valid_q  <= 1'b0;
            rel_idx_q    <= '0;
        end else begin
            func_rst_q  <= '0;
            rsp_valid_q <= 1'b0;
            rel_valid_q <= 1'b0;
            if (cfg_wr)
                vfe_q <= cfg_vfe;
            pend_q <= (pend_q & ~pick_hot) | set_mask;
            if (pick_found) begin
                rel_valid_q <= 1'b1;
                rel_idx_q   <= pick_idx;
                if (online_q[pick_idx]) begin
                    online_q[pick_idx]   <= 1'b0;
                    func_rst_q[pick_idx] <= 1'b1;
                end
            end else if (accept) begin
                rsp_valid_q <= 1'b1;
                unique case (outcome)
                    OUT_BAD_ID:  rsp_status_q <= ST_BAD_ID;
                    OUT_REFUSED: rsp_status_q <= ST_BAD_STATE;
                    OUT_RAISE: begin
                        rsp_status_q    <= ST_OK;
                        online_q[idx]   <= 1'b1;
                        func_rst_q[idx] <= 1'b1;
                    end
                    OUT_DROP: begin
                        rsp_status_q <= ST_OK;
                        rel_valid_q  <= 1'b1;
                        rel_idx_q    <= idx;
                        if (online_q[idx]) begin
                            online_q[idx]   <= 1'b0;
                            func_rst_q[idx] <= 1'b1;
                        end
                    end
                    default: rsp_status_q <= ST_OK;
                endcase
            end
        end
    end

    assign vfe        = vfe_q;
    assign rsp_valid  = rsp_valid_q;
    assign rsp_status = rsp_status_q;
    assign rel_valid  = rel_valid_q;
    assign rel_idx    = rel_idx_q;
    assign func_rst   = func_rst_q;
    assign online     = online_q;

    // R12
    one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(func_rst_q));

    // R12
    pulse_on_change_chk: assert property (@(posedge clk) disable iff (rst)
        (func_rst_q != '0) |-> ((func_rst_q & (online_q ^ $past(online_q))) == func_rst_q));

    // R4
    raise_needs_ok_chk: assert property (@(posedge clk) disable iff (rst)
        ((online_q & ~$past(online_q)) != '0) |-> (rsp_valid_q && rsp_status_q == ST_OK));

    // R2
    bad_id_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_q && rsp_status_q == ST_BAD_ID) |-> ($stable(online_q) && !rel_valid_q));

    // R11
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_q |-> $past(cmd_valid && cmd_ready));

    // R11
    ready_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q != '0) |=> !rsp_valid_q);

endmodule

// File: rtl/sec_access_gate.sv
module sec_access_gate
    import sec_gate_pkg::*;
#(
    parameter int NUM_SEC = 4,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_SEC-1:0]             online,
    input  logic [NUM_SEC-1:0]             en_req,
    output logic [NUM_SEC-1:0]             en_grant,
    input  logic [NUM_SEC-1:0]             acc_rd,
    input  logic [NUM_SEC-1:0]             acc_wr,
    input  logic [NUM_SEC-1:0][ADDR_W-1:0] acc_addr,
    input  logic [NUM_SEC-1:0][DATA_W-1:0] dn_rdata,
    output logic [NUM_SEC-1:0]             fwd_rd,
    output logic [NUM_SEC-1:0]             fwd_wr,
    output logic [NUM_SEC-1:0][DATA_W-1:0] up_rdata
);

    localparam logic [DATA_W-1:0] FATAL_MASK = DATA_W'(1) << STS_FATAL_BIT;

    generate
        for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
            logic is_sts, pass;

            always_comb begin
                is_sts      = (acc_addr[g] == ADDR_W'(STS_OFFSET));
                pass        = online[g] || is_sts;
                fwd_rd[g]   = acc_rd[g] && pass;
                fwd_wr[g]   = acc_wr[g] && pass;
                en_grant[g] = en_req[g] && online[g];
                if (!pass)
                    up_rdata[g] = '0;
                else if (!online[g])
                    up_rdata[g] = dn_rdata[g] | FATAL_MASK;
                else
                    up_rdata[g] = dn_rdata[g];
            end

            // R7
            offline_block_chk: assert property (@(posedge clk) disable iff (rst)
                (!online[g] && acc_addr[g] != ADDR_W'(STS_OFFSET))
                    |-> (!fwd_rd[g] && !fwd_wr[g] && up_rdata[g] == '0));

            // R8
            offline_fatal_chk: assert property (@(posedge clk) disable iff (rst)
                (!online[g] && acc_addr[g] == ADDR_W'(STS_OFFSET))
                    |-> up_rdata[g][STS_FATAL_BIT]);
        end
    endgenerate

endmodule

// File: rtl/sec_online_gate.sv
module sec_online_gate
    import sec_gate_pkg::*;
#(
    parameter int NUM_SEC = 4,
    parameter int ID_W    = 16,
    parameter int CNT_W   = 16,
    parameter int ID_BASE = 1,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = idx_width(NUM_SEC),
    localparam int VFC_W  = $clog2(NUM_SEC + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cmd_valid,
    output logic                           cmd_ready,
    input  logic                           cmd_online,
    input  logic [ID_W-1:0]                cmd_id,
    input  logic [CNT_W-1:0]               cmd_irq_cnt,
    input  logic [CNT_W-1:0]               cmd_q_cnt,
    output logic                           rsp_valid,
    output logic [15:0]                    rsp_status,
    output logic                           rel_valid,
    output logic [IDX_W-1:0]               rel_idx,
    input  logic                           cfg_wr,
    input  logic                           cfg_vfe,
    input  logic [VFC_W-1:0]               vf_count,
    input  logic                           prim_rst,
    output logic [NUM_SEC-1:0]             func_rst,
    output logic [NUM_SEC-1:0]             online,
    input  logic [NUM_SEC-1:0]             en_req,
    output logic [NUM_SEC-1:0]             en_grant,
    input  logic [NUM_SEC-1:0]             acc_rd,
    input  logic [NUM_SEC-1:0]             acc_wr,
    input  logic [NUM_SEC-1:0][ADDR_W-1:0] acc_addr,
    input  logic [NUM_SEC-1:0][DATA_W-1:0] dn_rdata,
    output logic [NUM_SEC-1:0]             fwd_rd,
    output logic [NUM_SEC-1:0]             fwd_wr,
    output logic [NUM_SEC-1:0][DATA_W-1:0] up_rdata
);

    logic             id_ok, can_online, vfe;
    logic [IDX_W-1:0] idx;

    sec_cmd_decode #(
        .NUM_SEC (NUM_SEC),
        .ID_W    (ID_W),
        .CNT_W   (CNT_W),
        .ID_BASE (ID_BASE)
    ) u_decode (
        .cmd_id     (cmd_id),
        .irq_cnt    (cmd_irq_cnt),
        .q_cnt      (cmd_q_cnt),
        .vfe        (vfe),
        .vf_count   (vf_count),
        .id_ok      (id_ok),
        .idx        (idx),
        .can_online (can_online)
    );

    sec_state_ctrl #(
        .NUM_SEC (NUM_SEC)
    ) u_state (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_online (cmd_online),
        .id_ok      (id_ok),
        .idx        (idx),
        .can_online (can_online),
        .cfg_wr     (cfg_wr),
        .cfg_vfe    (cfg_vfe),
        .vf_count   (vf_count),
        .prim_rst   (prim_rst),
        .vfe        (vfe),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .rel_valid  (rel_valid),
        .rel_idx    (rel_idx),
        .func_rst   (func_rst),
        .online     (online)
    );

    sec_access_gate #(
        .NUM_SEC (NUM_SEC),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_gate (
        .clk      (clk),
        .rst      (rst),
        .online   (online),
        .en_req   (en_req),
        .en_grant (en_grant),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr),
        .dn_rdata (dn_rdata),
        .fwd_rd   (fwd_rd),
        .fwd_wr   (fwd_wr),
        .up_rdata (up_rdata)
    );

endmodule

// File: tb/sec_online_gate_tb.sv
module sec_online_gate_tb;

    localparam int NS    = 4;
    localparam int ID_W  = 16;
    localparam int CNT_W = 16;
    localparam int AW    = 12;
    localparam int DW    = 32;
    localparam int IW    = 2;
    localparam int VW    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic                   cmd_valid = 0, cmd_online = 0;
    logic                   cmd_ready;
    logic [ID_W-1:0]        cmd_id = '0;
    logic [CNT_W-1:0]       cmd_irq_cnt = '0, cmd_q_cnt = '0;
    logic                   rsp_valid, rel_valid;
    logic [15:0]            rsp_status;
    logic [IW-1:0]          rel_idx;
    logic                   cfg_wr = 0, cfg_vfe = 0, prim_rst = 0;
    logic [VW-1:0]          vf_count = '0;
    logic [NS-1:0]          func_rst, online, en_grant, fwd_rd, fwd_wr;
    logic [NS-1:0]          en_req = '0, acc_rd = '0, acc_wr = '0;
    logic [NS-1:0][AW-1:0]  acc_addr = '0;
    logic [NS-1:0][DW-1:0]  dn_rdata = '0;
    logic [NS-1:0][DW-1:0]  up_rdata;

    sec_online_gate #(.NUM_SEC(NS), .ID_W(ID_W), .CNT_W(CNT_W), .ID_BASE(1),
                      .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_online(cmd_online), .cmd_id(cmd_id), .cmd_irq_cnt(cmd_irq_cnt),
        .cmd_q_cnt(cmd_q_cnt), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rel_valid(rel_valid), .rel_idx(rel_idx), .cfg_wr(cfg_wr), .cfg_vfe(cfg_vfe),
        .vf_count(vf_count), .prim_rst(prim_rst), .func_rst(func_rst), .online(online),
        .en_req(en_req), .en_grant(en_grant), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .dn_rdata(dn_rdata), .fwd_rd(fwd_rd), .fwd_wr(fwd_wr),
        .up_rdata(up_rdata)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // bench model of the registered state
    logic [NS-1:0] m_online = '0, m_pend = '0, m_fr = '0;
    logic          m_vfe = 0, m_rv = 0, m_relv = 0;
    logic [15:0]   m_st = '0;
    int            m_reli = 0;
    string         m_tag = "R1";

    task automatic chk(string tag, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] exp_rdata(logic on, logic [AW-1:0] a, logic [DW-1:0] d);
        if (a == AW'(32'h1C)) return on ? d : (d | 32'h2);
        return on ? d : '0;
    endfunction

    task automatic model_step();
        logic [NS-1:0] n_online = m_online, n_fr = '0, n_pend, set;
        logic n_rv = 0, n_relv = 0;
        logic [15:0] n_st = m_st;
        int n_reli = m_reli, pick = -1, id, ix;
        string tag = "R12";
        for (int i = 0; i < NS; i++) if (m_pend[i] && pick < 0) pick = i;
        set = prim_rst ? '1 : '0;
        if (cfg_wr && !cfg_vfe)
            for (int i = 0; i < NS; i++) if (i < int'(vf_count)) set[i] = 1'b1;
        n_pend = m_pend;
        if (pick >= 0) n_pend[pick] = 1'b0;
        n_pend |= set;
        if (pick >= 0) begin
            tag = "R11"; n_relv = 1; n_reli = pick;
            if (m_online[pick]) begin n_online[pick] = 0; n_fr[pick] = 1; end
        end else if (cmd_valid) begin
            n_rv = 1; id = int'(cmd_id);
            if (id < 1 || id > NS) begin
                tag = "R2"; n_st = 16'h011F;
            end else begin
                ix = id - 1;
                if (cmd_online) begin
                    if (cmd_irq_cnt == 0 || cmd_q_cnt < 2 || !m_vfe || ix >= int'(vf_count)) begin
                        tag = "R3"; n_st = 16'h0120;
                    end else if (m_online[ix]) begin
                        tag = "R5"; n_st = 0;
                    end else begin
                        tag = "R4"; n_st = 0; n_online[ix] = 1; n_fr[ix] = 1;
                    end
                end else begin
                    tag = "R6"; n_st = 0; n_relv = 1; n_reli = ix;
                    if (m_online[ix]) begin n_online[ix] = 0; n_fr[ix] = 1; end
                end
            end
        end
        if (cfg_wr) m_vfe = cfg_vfe;
        m_online = n_online; m_fr = n_fr; m_pend = n_pend; m_rv = n_rv;
        m_relv = n_relv; m_st = n_st; m_reli = n_reli; m_tag = tag;
    endtask

    task automatic check_regs();
        chk("R10", "cmd_ready", cmd_ready, m_pend == '0);
        chk(m_tag, "rsp_valid", rsp_valid, m_rv);
        if (m_rv) chk(m_tag, "rsp_status", rsp_status, m_st);
        chk(m_tag, "func_rst", func_rst, m_fr);
        chk("R12", "pulse count", $countones(func_rst) <= 1, 1);
        chk(m_tag, "rel_valid", rel_valid, m_relv);
        if (m_relv) chk(m_tag, "rel_idx", rel_idx, m_reli);
        chk(m_tag, "online", online, m_online);
    endtask

    // inputs are set by the caller at a falling edge; checks follow
    task automatic tick();
        #1;
        for (int i = 0; i < NS; i++) begin
            string t = (acc_addr[i] == AW'(32'h1C)) ? "R8" : "R7";
            logic pass = m_online[i] || (acc_addr[i] == AW'(32'h1C));
            chk(t, "fwd_rd", fwd_rd[i], acc_rd[i] && pass);
            chk(t, "fwd_wr", fwd_wr[i], acc_wr[i] && pass);
            chk(t, "up_rdata", up_rdata[i], exp_rdata(m_online[i], acc_addr[i], dn_rdata[i]));
            chk("R9", "en_grant", en_grant[i], en_req[i] && m_online[i]);
        end
        model_step();
        @(negedge clk);
        check_regs();
        cmd_valid = 0; cfg_wr = 0; prim_rst = 0;
    endtask

    task automatic send(logic on, int id, int irq, int q);
        cmd_valid = 1; cmd_online = on; cmd_id = ID_W'(id);
        cmd_irq_cnt = CNT_W'(irq); cmd_q_cnt = CNT_W'(q);
        tick();
    endtask

    task automatic rand_access();
        for (int i = 0; i < NS; i++) begin
            int r = $urandom_range(0, 3);
            acc_addr[i] = (r == 0) ? AW'(32'h1C) : (r == 1) ? AW'(32'h14) :
                          (r == 2) ? AW'(32'h00) : AW'($urandom_range(0, 255));
            dn_rdata[i] = $urandom();
            acc_rd[i]   = $urandom_range(0, 1) == 1;
            acc_wr[i]   = $urandom_range(0, 1) == 1;
            en_req[i]   = $urandom_range(0, 1) == 1;
        end
    endtask

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "online", online, 0);
        chk("R1", "cmd_ready", cmd_ready, 1);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "rel_valid", rel_valid, 0);
        chk("R1", "func_rst", func_rst, 0);

        rand_access();
        cfg_wr = 1; cfg_vfe = 1; vf_count = 3; tick();
        rand_access(); send(1, 1, 0, 4);   // R3 no interrupts
        rand_access(); send(1, 1, 1, 1);   // R3 one queue
        rand_access(); send(1, 4, 1, 2);   // R3 index 3 not backed
        rand_access(); send(1, 1, 1, 2);   // R4
        rand_access(); send(1, 1, 2, 3);   // R5
        rand_access(); send(1, 2, 1, 2);   // R4
        rand_access(); send(1, 0, 1, 2);   // R2
        rand_access(); send(0, 9, 1, 2);   // R2
        rand_access(); send(0, 3, 0, 0);   // R6 release only
        // R10 clearing the enable bit queues indices 0..2
        rand_access(); cfg_wr = 1; cfg_vfe = 0; tick();
        for (int k = 0; k < 4; k++) begin rand_access(); send(1, 1, 1, 2); end
        rand_access(); cfg_wr = 1; cfg_vfe = 1; vf_count = 4; tick();
        rand_access(); send(1, 4, 1, 2);
        rand_access(); send(1, 2, 1, 2);
        rand_access(); send(0, 2, 1, 2);   // R6 with reset
        rand_access(); send(1, 2, 1, 2);
        rand_access(); prim_rst = 1; tick(); // R10 primary reset
        for (int k = 0; k < 5; k++) begin rand_access(); tick(); end

        for (int n = 0; n < 4000; n++) begin
            rand_access();
            if ($urandom_range(0, 1) == 1) begin
                cmd_valid   = 1;
                cmd_online  = $urandom_range(0, 2) != 0;
                cmd_id      = ID_W'($urandom_range(0, 6));
                cmd_irq_cnt = CNT_W'($urandom_range(0, 3));
                cmd_q_cnt   = CNT_W'($urandom_range(0, 3));
            end
            if ($urandom_range(0, 39) == 0) begin
                cfg_wr = 1; cfg_vfe = $urandom_range(0, 2) != 0;
            end
            if ($urandom_range(0, 59) == 0) prim_rst = 1;
            if ($urandom_range(0, 29) == 0) vf_count = VW'($urandom_range(0, 4));
            tick();
        end
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule